// File: doc/BRIEF.md
# Multicycle Three-Instruction Processor Core

This block is a small processor that executes three instructions of a classic 32-bit load/store instruction set: a register-to-register add, a word load and a branch on equality. It does not overlap instructions. Each one moves through five phases in a fixed order before the next fetch begins: fetch, decode, operand read, execute, and write-back with the program-counter update. The core holds a 32-entry register file, a program counter, and two small word-organised memories for code and data.

Branches have one architectural delay slot. The instruction that follows a branch always runs. A taken branch takes effect only after that instruction has finished. A loader port fills either memory one word at a time, normally while reset is held. Debug outputs expose any register and the program counter. An unknown instruction stops the core and raises a sticky halt flag.

Top module: `tri_op_core`

## Requirements
- R1: Synchronous reset sets the PC to 0, clears the halt flag, clears all 32 registers and returns the core to the fetch phase.
- R2: Every instruction takes exactly five clock cycles. The PC changes only on the fifth cycle, so it first reads 4 five rising edges after reset is released, and 8 after ten.
- R3: A word with opcode bits [31:26] = 0 and funct bits [5:0] = 6'b100000 writes rs + rt into rd, where rs is bits [25:21], rt is bits [20:16] and rd is bits [15:11]. For example, 32'h012A4020 writes r9 + r10 into r8.
- R4: Register 0 always reads as zero, and a write that targets it has no effect.
- R5: A word with opcode 6'b100011 loads rt (bits [20:16]) from the data word at the address rs + offset. The offset is bits [15:0], sign-extended.
- R6: A word with opcode 6'b000100 compares rs with rt. When they are equal, the instruction after the branch still executes, and the fetch after it comes from the branch address + 4 + sign-extended offset × 4. Negative offsets branch backwards.
- R7: When a branch compares unequal, execution continues at the next sequential words. This includes the word at the branch address + 8.
- R8: Any other opcode, or opcode 0 with any funct other than 6'b100000, sets the halt flag. The halt flag then stays set and the PC keeps the address of the offending word until reset.
- R9: The two low bits of an instruction or data byte address are ignored when a memory word is selected. For example, a load from byte address 2 returns word 0.
- R10: While ld_en is high, each clock edge writes ld_data into word ld_word of the data memory (ld_dmem = 1) or the code memory (ld_dmem = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Memory loader write strobe |
| ld_dmem | input | 1 | Loader target: 1 for data memory, 0 for code memory |
| ld_word | input | 16 | Loader word index |
| ld_data | input | 32 | Loader write data |
| dbg_sel | input | 5 | Register number shown on dbg_val |
| dbg_val | output | 32 | Value of the selected register |
| dbg_pc | output | 32 | Current program counter (byte address) |
| halted | output | 1 | Sticky stop flag for an unknown instruction |

## Verification
The bench builds the core with a 32-word code memory and a 16-word data memory. These sizes are small enough that the word index is cut from only a few address bits, yet large enough to hold a 19-word program. That program covers a taken forward branch, a branch that falls through, a taken backward branch that forms a two-pass loop, and loads with positive, negative and unaligned offsets. It ends on an unknown opcode. A second run then places an add with a wrong funct at address 0, so the core halts on its very first instruction.

// File: rtl/tri_op_core.sv
module tri_op_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_en,
  input  logic        ld_dmem,
  input  logic [15:0] ld_word,
  input  logic [31:0] ld_data,
  input  logic [4:0]  dbg_sel,
  output logic [31:0] dbg_val,
  output logic [31:0] dbg_pc,
  output logic        halted
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  typedef enum logic [2:0] {PH_FETCH, PH_DECODE, PH_OPRD, PH_EXEC, PH_WB} phase_t;
  typedef enum logic [1:0] {K_ADD, K_LW, K_BEQ} kind_t;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];

  phase_t      phase;
  kind_t       kind;
  logic [31:0] pc, npc, ir, opa, opb, res;
  logic        take;

  wire [5:0]  f_op   = ir[31:26];
  wire [4:0]  f_rs   = ir[25:21];
  wire [4:0]  f_rt   = ir[20:16];
  wire [4:0]  f_rd   = ir[15:11];
  wire [5:0]  f_fn   = ir[5:0];
  wire [31:0] imm_sx = {{16{ir[15]}}, ir[15:0]};
  wire [31:0] imm_wd = {{14{ir[15]}}, ir[15:0], 2'b00};
  wire [31:0] ea     = opa + imm_sx;

  wire is_add = (f_op == 6'h00) && (f_fn == 6'h20);
  wire is_lw  = (f_op == 6'h23);
  wire is_beq = (f_op == 6'h04);

  logic unused_bits;
  assign unused_bits = ^{ir[10:6], ea, ld_word};

  assign dbg_pc  = pc;
  assign dbg_val = (dbg_sel == 5'd0) ? 32'd0 : rf[dbg_sel];

  always_ff @(posedge clk) begin
    if (ld_en) begin
      if (ld_dmem) dmem[ld_word[DAW-1:0]] <= ld_data;
      else         imem[ld_word[IAW-1:0]] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_FETCH;
      kind   <= K_ADD;
      pc     <= 32'd0;
      npc    <= 32'd4;
      ir     <= 32'd0;
      opa    <= 32'd0;
      opb    <= 32'd0;
      res    <= 32'd0;
      take   <= 1'b0;
      halted <= 1'b0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (!halted) begin
      unique case (phase)
        PH_FETCH: begin
          ir    <= imem[pc[IAW+1:2]];
          phase <= PH_DECODE;
        end
        PH_DECODE: begin
          if (is_add) begin
            kind  <= K_ADD;
            phase <= PH_OPRD;
          end else if (is_lw) begin
            kind  <= K_LW;
            phase <= PH_OPRD;
          end else if (is_beq) begin
            kind  <= K_BEQ;
            phase <= PH_OPRD;
          end else begin
            halted <= 1'b1;
          end
        end
        PH_OPRD: begin
          opa   <= (f_rs == 5'd0) ? 32'd0 : rf[f_rs];
          opb   <= (f_rt == 5'd0) ? 32'd0 : rf[f_rt];
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          unique case (kind)
            K_ADD:   res  <= opa + opb;
            K_LW:    res  <= dmem[ea[DAW+1:2]];
            default: take <= (opa == opb);
          endcase
          phase <= PH_WB;
        end
        default: begin
          if (kind == K_ADD && f_rd != 5'd0) rf[f_rd] <= res;
          if (kind == K_LW  && f_rt != 5'd0) rf[f_rt] <= res;
          pc    <= npc;
          npc   <= (kind == K_BEQ && take) ? pc + 32'd4 + imm_wd : npc + 32'd4;
          phase <= PH_FETCH;
        end
      endcase
    end
  end

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH && !halted) |=> (phase == PH_DECODE));

  // R2
  wb_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WB && !halted) |=> (phase == PH_FETCH));

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_WB) |=> $stable(pc));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(pc) && $stable(phase)));
endmodule

// File: tb/sim_tri_op_core.sv
module sim_tri_op_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [15:0] ld_word = 16'd0;
  logic [31:0] ld_data = 32'd0;
  logic [4:0]  dbg_sel = 5'd0;
  logic [31:0] dbg_val, dbg_pc;
  logic        halted;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [4:0]  rnum;
    logic [31:0] val;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  tri_op_core #(.IMEM_WORDS(32), .DMEM_WORDS(16)) u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_word(ld_word),
    .ld_data(ld_data), .dbg_sel(dbg_sel), .dbg_val(dbg_val), .dbg_pc(dbg_pc),
    .halted(halted)
  );

  function automatic logic [31:0] enc_add(int rs, int rt, int rd);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'h20};
  endfunction

  function automatic logic [31:0] enc_imm(logic [5:0] op, int rs, int rt, logic [15:0] off);
    return {op, rs[4:0], rt[4:0], off};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_reg(string tag, int r, logic [31:0] v);
    exp_t e;
    e.tag = tag;
    e.rnum = r[4:0];
    e.val = v;
    sb.push_back(e);
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic load_word(bit d, int idx, logic [31:0] w);
    @(negedge clk);
    ld_en = 1'b1;
    ld_dmem = d;
    ld_word = idx[15:0];
    ld_data = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        dbg_sel = e.rnum;
        #1;
        chk($sformatf("%s r%0d", e.tag, e.rnum), dbg_val, e.val);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected halt");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10 preload data memory
    load_word(1, 0, 32'h1111_0000);
    load_word(1, 1, 32'h0000_2222);
    load_word(1, 3, 32'h0000_0007);
    load_word(1, 5, 32'hCAFE_BABE);
    // program
    load_word(0, 0,  enc_imm(6'h23, 0, 9, 16'd4));
    load_word(0, 1,  enc_imm(6'h23, 0, 10, 16'd20));
    load_word(0, 2,  32'h012A4020);
    load_word(0, 3,  enc_add(9, 10, 0));
    load_word(0, 4,  enc_imm(6'h23, 0, 11, 16'd2));
    load_word(0, 5,  enc_imm(6'h23, 0, 12, 16'd12));
    load_word(0, 6,  enc_imm(6'h04, 9, 9, 16'd3));
    load_word(0, 7,  enc_add(12, 12, 13));
    load_word(0, 8,  enc_add(12, 12, 14));
    load_word(0, 9,  enc_add(9, 9, 14));
    load_word(0, 10, enc_imm(6'h04, 9, 10, 16'd5));
    load_word(0, 11, enc_add(9, 12, 15));
    load_word(0, 12, enc_imm(6'h23, 12, 20, 16'hFFFD));
    load_word(0, 13, enc_imm(6'h04, 0, 0, 16'd2));
    load_word(0, 14, enc_add(13, 13, 17));
    load_word(0, 15, enc_add(12, 0, 18));
    load_word(0, 16, enc_imm(6'h04, 18, 0, 16'hFFFE));
    load_word(0, 17, enc_add(19, 12, 19));
    load_word(0, 18, 32'hFC00_0000);

    @(negedge clk);
    chk("R1 reset pc", dbg_pc, 32'd0);
    chk("R1 reset halt", {31'd0, halted}, 32'd0);
    expect_reg("R1 reset reg", 9, 32'd0);
    drain();

    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 pc after 4 edges", dbg_pc, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 pc after 5 edges", dbg_pc, 32'd4);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R2 pc after 10 edges", dbg_pc, 32'd8);

    while (!halted) @(negedge clk);
    @(negedge clk);
    chk("R8 halt pc", dbg_pc, 32'h48);
    expect_reg("R5 load positive offset", 9, 32'h0000_2222);
    expect_reg("R5 load word 5", 10, 32'hCAFE_BABE);
    expect_reg("R3 add 012A4020", 8, 32'hCAFE_DCE0);
    expect_reg("R4 r0 write ignored", 0, 32'd0);
    expect_reg("R9 unaligned load", 11, 32'h1111_0000);
    expect_reg("R5 load word 3", 12, 32'd7);
    expect_reg("R6 delay slot ran", 13, 32'd14);
    expect_reg("R6 skipped words", 14, 32'd0);
    expect_reg("R7 not-taken slot", 15, 32'h0000_2229);
    expect_reg("R7 R5 fall-through negative load", 20, 32'h0000_2222);
    expect_reg("R6 second slot", 17, 32'd28);
    expect_reg("R6 backward target", 18, 32'd7);
    expect_reg("R6 loop two passes", 19, 32'd14);
    expect_reg("R4 untouched reg", 1, 32'd0);
    drain();
    repeat (12) @(negedge clk);
    chk("R8 pc frozen", dbg_pc, 32'h48);
    chk("R8 halt sticky", {31'd0, halted}, 32'd1);

    rst = 1'b1;
    load_word(0, 0, 32'h012A4021);
    load_word(0, 1, enc_add(9, 10, 8));
    @(negedge clk);
    chk("R1 halt cleared", {31'd0, halted}, 32'd0);
    expect_reg("R1 reg cleared", 8, 32'd0);
    drain();
    rst = 1'b0;
    repeat (12) @(negedge clk);
    chk("R8 bad funct halt", {31'd0, halted}, 32'd1);
    chk("R8 bad funct pc", dbg_pc, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule